// File: doc/BRIEF.md
# HDLC Receive Interrupt Controller

This block gathers single-cycle event pulses from an HDLC receiver and latches each into a sticky bit of an event register. A per-bit enable mask decides which latched events may raise the interrupt line. The host reaches the block through a serial port adapter. That adapter turns the serial transfers into three things: a byte write of the mask, a parallel view of the event register, and two strobes that frame a read of that register. The first strobe marks the serial clock falling edge that follows the command byte of an event-register read. The second strobe marks the end of that read cycle.

Event bits are sticky records of an event. They are not live conditions. When a read ends, the register is cleared. Events that arrived during the read, and whose bit was not already set, are then written into the cleared register, so no new event is hidden by the clear. One event bit is shared between the receive frame-abort event and the transmit underrun event, and a select input picks which of the two it records. All pins are plain control and status signals. There is no streamed data, so no handshake is needed.

Top module: `hdlc_rx_irq_ctrl`

## Requirements
- R1: After an asynchronous reset (`rst_n` low) or a synchronous soft reset (`soft_rst` high at a clock edge), the event register reads 0, the mask is all zeros, any read in progress is abandoned and `irq` is low.
- R2: Outside a read, an event pulse sampled at a clock edge sets its bit from that edge. The bit positions are: bit 0 go-ahead, bit 1 end-of-packet detected, bit 2 end-of-packet read, bit 3 shared abort/underrun, bit 4 FIFO filling, bit 5 FIFO overflow. A masked event sets its bit and leaves `irq` low.
- R3: When an event sets a bit whose mask bit is 1, `irq` is high from the same edge.
- R4: With `sel_txun` low, bit 3 records `ev_abort` and ignores `ev_tx_under`. With `sel_txun` high, bit 3 records `ev_tx_under` and ignores `ev_abort`.
- R5: The edge that samples `rd_start` while idle begins a read. From that edge until the edge that ends the read, `irq` is low and the event register holds its value, whatever events arrive.
- R6: The edge that samples `rd_done` during a read ends it. The event register becomes the set of bits whose events arrived during the read while that bit was clear, plus any event sampled at that same edge. Events for bits that were already set during the read are dropped.
- R7: Once the read ends, `irq` again equals the OR over bits of (event AND mask).
- R8: A mask write (`en_wr`) loads `en_wdata[5:0]`. Bits 7:6 of `en_wdata` are ignored, and bits 7:6 of `stat_rdata` always read 0.
- R9: `rd_start` during a read, and `rd_done` outside a read, have no effect.
- R10: A mask write takes effect at once on events already latched. Clearing a mask bit drops `irq` without touching the event register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous software reset |
| en_wr | input | 1 | Mask write strobe |
| en_wdata | input | 8 | Mask write byte |
| rd_start | input | 1 | Serial clock falling edge after an event-read command byte |
| rd_done | input | 1 | End of the event-register read cycle |
| sel_txun | input | 1 | Shared bit select: 0 abort, 1 transmit underrun |
| ev_go_ahead | input | 1 | Go-ahead pattern seen |
| ev_eop_det | input | 1 | End-of-packet byte written to receive FIFO |
| ev_eop_read | input | 1 | Next FIFO byte ends a packet, or FIFO read while empty |
| ev_abort | input | 1 | Frame abort received |
| ev_tx_under | input | 1 | Transmitter underrun |
| ev_fifo_fill | input | 1 | Receive FIFO crossed its filling threshold |
| ev_fifo_ovfl | input | 1 | Write to a full receive FIFO |
| stat_rdata | output | 8 | Latched event register |
| irq | output | 1 | Interrupt request, active high |

## Verification
The stimulus covers a masked single event, an unmasked event, and a mask change over a register that is already set. Together these show that latching does not depend on the mask while the interrupt does. One read carries, in the middle of the read, an event for a clear bit and another for a bit already set: the first must appear after the read and the second must be gone. A further read ends on the same edge as an incoming event, and one read is broken by a soft reset. The shared bit is driven with each of its two sources under both select values, so a wrong or inverted select shows up.

// File: rtl/hrx_irq_pkg.sv
package hrx_irq_pkg;
  localparam int NEV       = 6;
  localparam int IDX_GA    = 0;
  localparam int IDX_EOPD  = 1;
  localparam int IDX_EOPR  = 2;
  localparam int IDX_SHARE = 3;
  localparam int IDX_FILL  = 4;
  localparam int IDX_OVFL  = 5;

  typedef logic [NEV-1:0] ev_vec_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_START = 2'b01,
    PH_HOLD  = 2'b10,
    PH_END   = 2'b11
  } rd_phase_e;
endpackage

// File: rtl/hrx_irq_evmap.sv
module hrx_irq_evmap
  import hrx_irq_pkg::*;
(
  input  logic    ev_go_ahead,
  input  logic    ev_eop_det,
  input  logic    ev_eop_read,
  input  logic    ev_abort,
  input  logic    ev_tx_under,
  input  logic    ev_fifo_fill,
  input  logic    ev_fifo_ovfl,
  input  logic    sel_txun,
  output ev_vec_t ev_vec
);
  always_comb begin
    ev_vec            = '0;
    ev_vec[IDX_GA]    = ev_go_ahead;
    ev_vec[IDX_EOPD]  = ev_eop_det;
    ev_vec[IDX_EOPR]  = ev_eop_read;
    ev_vec[IDX_SHARE] = sel_txun ? ev_tx_under : ev_abort;
    ev_vec[IDX_FILL]  = ev_fifo_fill;
    ev_vec[IDX_OVFL]  = ev_fifo_ovfl;
  end
endmodule

// File: rtl/hrx_irq_latch.sv
module hrx_irq_latch
  import hrx_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    soft_rst,
  input  ev_vec_t ev_vec,
  input  logic    rd_start,
  input  logic    rd_done,
  output ev_vec_t stat_q,
  output ev_vec_t held_q,
  output logic    busy_q
);
  rd_phase_e phase;
  ev_vec_t   stat_d;
  ev_vec_t   held_d;
  logic      busy_d;

  always_comb begin
    if (!busy_q)
      phase = rd_start ? PH_START : PH_IDLE;
    else
      phase = rd_done ? PH_END : PH_HOLD;
  end

  always_comb begin
    stat_d = stat_q;
    held_d = held_q;
    busy_d = busy_q;
    unique case (phase)
      PH_IDLE: stat_d = stat_q | ev_vec;
      PH_START: begin
        busy_d = 1'b1;
        held_d = ev_vec & ~stat_q;
      end
      PH_HOLD: held_d = held_q | (ev_vec & ~stat_q);
      PH_END: begin
        busy_d = 1'b0;
        stat_d = held_q | ev_vec;
        held_d = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      held_q <= '0;
      busy_q <= 1'b0;
    end else if (soft_rst) begin
      stat_q <= '0;
      held_q <= '0;
      busy_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      held_q <= held_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/hrx_irq_mask.sv
module hrx_irq_mask
  import hrx_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    soft_rst,
  input  logic    en_wr,
  input  ev_vec_t en_wbits,
  input  ev_vec_t stat_q,
  input  logic    busy_q,
  output logic    irq
);
  ev_vec_t en_q;
  ev_vec_t hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= '0;
    else if (soft_rst) en_q <= '0;
    else if (en_wr)    en_q <= en_wbits;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NEV; gi++) begin : g_hit
      assign hit[gi] = stat_q[gi] & en_q[gi];
    end
  endgenerate

  assign irq = (|hit) & ~busy_q;
endmodule

// File: rtl/hdlc_rx_irq_ctrl.sv
module hdlc_rx_irq_ctrl
  import hrx_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          en_wr,
  input  logic [DW-1:0] en_wdata,
  input  logic          rd_start,
  input  logic          rd_done,
  input  logic          sel_txun,
  input  logic          ev_go_ahead,
  input  logic          ev_eop_det,
  input  logic          ev_eop_read,
  input  logic          ev_abort,
  input  logic          ev_tx_under,
  input  logic          ev_fifo_fill,
  input  logic          ev_fifo_ovfl,
  output logic [DW-1:0] stat_rdata,
  output logic          irq
);
  localparam int PAD = DW - NEV;

  ev_vec_t ev_vec;
  ev_vec_t stat_q;
  ev_vec_t held_ev;
  logic    rd_busy;
  logic    unused_hi;

  assign unused_hi = ^en_wdata[DW-1:NEV];

  hrx_irq_evmap u_evmap (
    .ev_go_ahead (ev_go_ahead),
    .ev_eop_det  (ev_eop_det),
    .ev_eop_read (ev_eop_read),
    .ev_abort    (ev_abort),
    .ev_tx_under (ev_tx_under),
    .ev_fifo_fill(ev_fifo_fill),
    .ev_fifo_ovfl(ev_fifo_ovfl),
    .sel_txun    (sel_txun),
    .ev_vec      (ev_vec)
  );

  hrx_irq_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .ev_vec  (ev_vec),
    .rd_start(rd_start),
    .rd_done (rd_done),
    .stat_q  (stat_q),
    .held_q  (held_ev),
    .busy_q  (rd_busy)
  );

  hrx_irq_mask u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .en_wr   (en_wr),
    .en_wbits(en_wdata[NEV-1:0]),
    .stat_q  (stat_q),
    .busy_q  (rd_busy),
    .irq     (irq)
  );

  assign stat_rdata = {{PAD{1'b0}}, stat_q};
endmodule

// File: rtl/hdlc_rx_irq_ctrl_sva.sv
module hdlc_rx_irq_ctrl_sva
  import hrx_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic          rd_start,
  input logic          rd_done,
  input logic          sel_txun,
  input logic          ev_go_ahead,
  input logic          ev_abort,
  input logic          ev_tx_under,
  input logic [DW-1:0] stat_rdata,
  input logic          irq,
  input logic          rd_busy,
  input ev_vec_t       held_ev
);
  a_r1_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (stat_rdata == '0) && !irq);

  a_r2_ga_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_busy && !rd_start && !soft_rst && ev_go_ahead) |=> stat_rdata[IDX_GA]);

  a_r4_abort_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_busy && !rd_start && !soft_rst && !sel_txun && ev_abort) |=> stat_rdata[IDX_SHARE]);

  a_r4_under_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_busy && !rd_start && !soft_rst && sel_txun && ev_tx_under) |=> stat_rdata[IDX_SHARE]);

  a_r5_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !(rd_busy && rd_done)) |=> !irq);

  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && !rd_done && !soft_rst) |=> $stable(stat_rdata));

  a_r6_post_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && rd_done && !soft_rst) |=>
      ((stat_rdata[NEV-1:0] & $past(held_ev)) == $past(held_ev)));
endmodule

bind hdlc_rx_irq_ctrl hdlc_rx_irq_ctrl_sva #(.DW(DW)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .rd_start   (rd_start),
  .rd_done    (rd_done),
  .sel_txun   (sel_txun),
  .ev_go_ahead(ev_go_ahead),
  .ev_abort   (ev_abort),
  .ev_tx_under(ev_tx_under),
  .stat_rdata (stat_rdata),
  .irq        (irq),
  .rd_busy    (rd_busy),
  .held_ev    (held_ev)
);

// File: tb/hdlc_rx_irq_ctrl_test.sv
`timescale 1ns/1ps
module hdlc_rx_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       en_wr = 1'b0;
  logic [7:0] en_wdata = '0;
  logic       rd_start = 1'b0;
  logic       rd_done = 1'b0;
  logic       sel_txun = 1'b0;
  logic [6:0] evs = '0;
  logic [7:0] stat_rdata;
  logic       irq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R1";

  logic [5:0] m_stat = '0, m_en = '0, m_held = '0;
  logic       m_busy = 1'b0;

  always #5 clk = ~clk;

  hdlc_rx_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .en_wr(en_wr), .en_wdata(en_wdata),
    .rd_start(rd_start), .rd_done(rd_done), .sel_txun(sel_txun),
    .ev_go_ahead(evs[0]), .ev_eop_det(evs[1]), .ev_eop_read(evs[2]),
    .ev_abort(evs[3]), .ev_tx_under(evs[6]),
    .ev_fifo_fill(evs[4]), .ev_fifo_ovfl(evs[5]),
    .stat_rdata(stat_rdata), .irq(irq)
  );

  // behavioural reference, updated on each rising edge
  always @(posedge clk or negedge rst_n) begin
    logic [5:0] e;
    if (!rst_n) begin
      m_stat = '0; m_en = '0; m_held = '0; m_busy = 1'b0;
    end else if (soft_rst) begin
      m_stat = '0; m_en = '0; m_held = '0; m_busy = 1'b0;
    end else begin
      e = {evs[5], evs[4], (sel_txun ? evs[6] : evs[3]), evs[2], evs[1], evs[0]};
      if (en_wr) m_en = en_wdata[5:0];
      if (!m_busy) begin
        if (rd_start) begin m_busy = 1'b1; m_held = e & ~m_stat; end
        else m_stat = m_stat | e;
      end else if (rd_done) begin
        m_stat = m_held | e; m_held = '0; m_busy = 1'b0;
      end else begin
        m_held = m_held | (e & ~m_stat);
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(stat_rdata == {2'b00, m_stat}, cur_req, stat_rdata, {2'b00, m_stat});
      chk(irq == (((m_stat & m_en) != 0) && !m_busy), cur_req, {7'd0, irq},
          {7'd0, (((m_stat & m_en) != 0) && !m_busy)});
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_ev(input logic [6:0] m);
    evs = m; step(); evs = '0;
  endtask

  task automatic wr_en(input logic [7:0] v);
    en_wr = 1'b1; en_wdata = v; step(); en_wr = 1'b0;
  endtask

  task automatic pstart();
    rd_start = 1'b1; step(); rd_start = 1'b0;
  endtask

  task automatic pdone();
    rd_done = 1'b1; step(); rd_done = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [7:0] s, input logic i);
    chk(stat_rdata == s, req, stat_rdata, s);
    chk(irq == i, req, {7'd0, irq}, {7'd0, i});
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    cur_req = "R1"; expect_out("R1", 8'h00, 1'b0);

    cur_req = "R2"; pulse_ev(7'h01); expect_out("R2", 8'h01, 1'b0);
    cur_req = "R10"; wr_en(8'h3F); expect_out("R10", 8'h01, 1'b1);
    cur_req = "R3"; pulse_ev(7'h10); expect_out("R3", 8'h11, 1'b1);

    cur_req = "R5"; pstart(); expect_out("R5", 8'h11, 1'b0);
    pulse_ev(7'h02); expect_out("R5", 8'h11, 1'b0);
    pulse_ev(7'h10); expect_out("R5", 8'h11, 1'b0);
    cur_req = "R9"; pstart(); expect_out("R9", 8'h11, 1'b0);
    cur_req = "R6"; pdone(); expect_out("R6", 8'h02, 1'b1);
    cur_req = "R7"; step(); expect_out("R7", 8'h02, 1'b1);

    cur_req = "R10"; wr_en(8'h00); expect_out("R10", 8'h02, 1'b0);
    cur_req = "R6"; pstart(); pdone(); expect_out("R6", 8'h00, 1'b0);

    cur_req = "R9"; pulse_ev(7'h01); pdone(); expect_out("R9", 8'h01, 1'b0);
    pstart(); pdone(); expect_out("R9", 8'h00, 1'b0);

    cur_req = "R4"; sel_txun = 1'b0;
    pulse_ev(7'h40); expect_out("R4", 8'h00, 1'b0);
    pulse_ev(7'h08); expect_out("R4", 8'h08, 1'b0);
    pstart(); pdone();
    sel_txun = 1'b1;
    pulse_ev(7'h08); expect_out("R4", 8'h00, 1'b0);
    pulse_ev(7'h40); expect_out("R4", 8'h08, 1'b0);
    pstart(); pdone(); sel_txun = 1'b0;

    cur_req = "R6"; pstart();
    rd_done = 1'b1; evs = 7'h20; step(); rd_done = 1'b0; evs = '0;
    expect_out("R6", 8'h20, 1'b0);

    cur_req = "R8"; wr_en(8'hC0); expect_out("R8", 8'h20, 1'b0);
    pulse_ev(7'h3F); expect_out("R8", 8'h3F, 1'b0);
    wr_en(8'hE0); expect_out("R8", 8'h3F, 1'b1);

    cur_req = "R1"; pstart(); pulse_ev(7'h01);
    soft_rst = 1'b1; step(); soft_rst = 1'b0;
    expect_out("R1", 8'h00, 1'b0);
    pulse_ev(7'h01); expect_out("R1", 8'h01, 1'b0);

    repeat (2) step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 2000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 2000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule